// File: doc/BRIEF.md
# Three-Phase Sine PWM Modulator

The block turns an amplitude command and a rotor phase position into three sine-weighted PWM demands, one for each of the high-side switches of phases U, V and W. All three phases are compared against one shared triangular carrier. The carrier is a 6-bit up/down count that takes exactly 252 clock cycles per period. A strobe marks the top of each carrier period for downstream logic.

Each phase picks a point on a sine-shaped curve. The index is the rotor position word plus a lead-angle offset, and phases V and W trail U by one third and two thirds of a turn. The lead angle arrives as a 5-bit request together with lower and upper clip codes. The block clips the request to those codes and converts it to a position offset spanning 0° to 58°.

The amplitude command and the clipped lead angle are captured only at the carrier peak, so a duty cycle never changes part-way through a carrier period. When the captured amplitude is very small, the block enters a refresh mode. In this mode the high-side demands stay off and a separate strobe drives the low-side switches at about 8% duty, so that bootstrap capacitors stay charged.

Top module: `spwm_modulator`

## Requirements
- R1: The carrier runs 0,1,…,63,62,…,1 and then repeats, with every value held for two clocks, which gives a period of 252 clocks. `carrierPeak` is high for exactly one clock per period, while the carrier is at 63. After reset is released, it is first seen in the cycle that follows the 126th rising edge taken with reset low.
- R2: The sine shape for an 8-bit index p is computed as follows. Take x = p[6:0] and d = min(31, floor(x·(128−x)/128)). The shape value is 32+d when p[7]=0 and 32−d when p[7]=1, so it ranges from 1 to 63.
- R3: A phase's modulating value is M = floor(shape·amp/256). The demand is high in each clock where M is greater than the carrier, so a period holds 4M−2 high clocks for M≥1 and none for M=0.
- R4: With base = (rotorPos + offset) mod 256, the U index is base, the V index is (base − 85) mod 256 and the W index is (base − 171) mod 256. Bit 0 of `pwmHigh` is U, bit 1 is V and bit 2 is W.
- R5: A clipped lead code c gives the position offset floor(c·14848/11160): code 0 gives 0 and code 31 gives 41, which is 58° of a 256-step turn.
- R6: When leadLo ≤ leadHi, the applied code is the request clamped into [leadLo, leadHi].
- R7: When leadLo > leadHi, the applied code is leadLo, whatever the request.
- R8: The amplitude and lead inputs are captured only in the `carrierPeak` cycle. A change made in any other cycle has no effect on the outputs until after the next peak.
- R9: When the captured amplitude is below 16, `pwmHigh` stays 0 and `lowRefresh` is high for the first 20 clocks of each 252-clock period. When the captured amplitude is 16 or more, `lowRefresh` stays 0.
- R10: While reset is held, `pwmHigh`, `lowRefresh` and `carrierPeak` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ampCmd | input | 8 | Amplitude command, captured at the carrier peak |
| rotorPos | input | 8 | Rotor phase position, 256 steps per electrical turn |
| leadReq | input | 5 | Requested lead-angle code |
| leadLo | input | 5 | Lower clip code for the lead angle |
| leadHi | input | 5 | Upper clip code for the lead angle |
| pwmHigh | output | 3 | High-side PWM demands for W, V, U (bit 2 down to bit 0) |
| lowRefresh | output | 1 | Low-side refresh strobe in refresh mode |
| carrierPeak | output | 1 | One-clock strobe at the top of the carrier |

## Verification
The output registers add one cycle, so `pwmHigh` and `lowRefresh` in a given cycle reflect the carrier, position and captured values of the previous cycle. New amplitude or lead values only take effect after the next `carrierPeak` cycle. The bench therefore waits for a peak after changing any input, then counts high clocks over the next 252 cycles. That window covers exactly one carrier period and exactly one captured setting, so the count can be compared with 4M−2 or with 20. The timing of the peak strobe is checked against the 126th and 378th rising edges after reset. The capture rule is checked by changing the amplitude in the cycle right after a peak, and confirming that the whole following window still shows the old duty.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  // Strobes passed from the carrier sequencer to the datapath.
  typedef struct packed {
    logic peak;        // carrier at its top value, first of its two clocks
    logic refreshWin;  // inside the low-side refresh window of the period
  } spwmStrb_t;

endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl
  import spwm_pkg::*;
#(
  parameter int CAR_W   = 6,
  parameter int REF_PCT = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CAR_W-1:0] carrier,
  output spwmStrb_t        strb
);

  localparam int CAR_MAX  = 2**CAR_W - 1;
  localparam int PERIOD   = 4 * CAR_MAX;
  localparam int PEAK_AT  = 2 * CAR_MAX;
  localparam int PCNT_W   = $clog2(PERIOD);
  localparam int REF_CLKS = (PERIOD * REF_PCT + 50) / 100;

  logic [PCNT_W-1:0] periodCnt;

  // One count per clock; bit 0 acts as the divide-by-two step prescaler.
  always_ff @(posedge clk) begin
    if (rst) begin
      periodCnt <= '0;
    end else if (periodCnt == PCNT_W'(PERIOD - 1)) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  // Rising slope for the first half, falling slope mirrored about the peak.
  always_comb begin
    if (int'(periodCnt) <= PEAK_AT + 1) begin
      carrier = CAR_W'(periodCnt >> 1);
    end else begin
      carrier = CAR_W'((PERIOD + 1 - int'(periodCnt)) >> 1);
    end
    strb.peak       = (int'(periodCnt) == PEAK_AT);
    strb.refreshWin = (int'(periodCnt) < REF_CLKS);
  end

  a_r1_peak_top: assert property (@(posedge clk) disable iff (rst)
    strb.peak |-> (int'(carrier) == CAR_MAX));

  a_r1_unit_slope: assert property (@(posedge clk) disable iff (rst)
    (int'(carrier) - int'($past(carrier))) inside {-1, 0, 1});

  a_r1_single_peak: assert property (@(posedge clk) disable iff (rst)
    strb.peak |=> !strb.peak);

endmodule

// File: rtl/spwm_wave.sv
module spwm_wave #(
  parameter int POS_W = 8,
  parameter int CAR_W = 6
) (
  input  logic [POS_W-1:0] idx,
  output logic [CAR_W-1:0] wave
);

  localparam int QW  = 2**(POS_W - 1);
  localparam int MID = 2**(CAR_W - 1);

  // Parabolic half-wave per half turn: peak near MID, mirrored below MID.
  always_comb begin
    int x;
    int d;
    x = int'(idx[POS_W-2:0]);
    d = ((x * (QW - x)) << (CAR_W + 1)) >> (2 * (POS_W - 1));
    if (d > MID - 1) d = MID - 1;
    if (idx[POS_W-1]) begin
      wave = CAR_W'(MID - d);
    end else begin
      wave = CAR_W'(MID + d);
    end
  end

endmodule

// File: rtl/spwm_datapath.sv
module spwm_datapath
  import spwm_pkg::*;
#(
  parameter int CAR_W       = 6,
  parameter int AMP_W       = 8,
  parameter int POS_W       = 8,
  parameter int LA_W        = 5,
  parameter int LEAD_DEG    = 58,
  parameter int REFRESH_AMP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CAR_W-1:0] carrier,
  input  spwmStrb_t        strb,
  input  logic [AMP_W-1:0] ampCmd,
  input  logic [POS_W-1:0] rotorPos,
  input  logic [LA_W-1:0]  leadReq,
  input  logic [LA_W-1:0]  leadLo,
  input  logic [LA_W-1:0]  leadHi,
  output logic [2:0]       pwmHigh,
  output logic             lowRefresh
);

  localparam int NPH      = 3;
  localparam int LEAD_NUM = LEAD_DEG * (2**POS_W);
  localparam int LEAD_DEN = (2**LA_W - 1) * 360;
  localparam int PH120    = (2**POS_W + 1) / 3;
  localparam int PH240    = (2 * 2**POS_W + 1) / 3;

  logic [LA_W-1:0]  clippedLead;
  logic [POS_W-1:0] leadOffNext;
  logic [AMP_W-1:0] ampQ;
  logic [LA_W-1:0]  leadQ;
  logic [POS_W-1:0] leadOffQ;
  logic [POS_W-1:0] baseIdx;
  logic [POS_W-1:0] phaseIdx [NPH];
  logic [NPH-1:0]   demandNext;
  logic             refreshActive;

  // Lower clip wins when the limits cross.
  always_comb begin
    if (leadLo > leadHi) begin
      clippedLead = leadLo;
    end else if (leadReq < leadLo) begin
      clippedLead = leadLo;
    end else if (leadReq > leadHi) begin
      clippedLead = leadHi;
    end else begin
      clippedLead = leadReq;
    end
    leadOffNext = POS_W'((int'(clippedLead) * LEAD_NUM) / LEAD_DEN);
  end

  assign refreshActive = (int'(ampQ) < REFRESH_AMP);

  always_comb begin
    baseIdx     = rotorPos + leadOffQ;
    phaseIdx[0] = baseIdx;
    phaseIdx[1] = baseIdx - POS_W'(PH120);
    phaseIdx[2] = baseIdx - POS_W'(PH240);
  end

  for (genvar ph = 0; ph < NPH; ph++) begin : gPhase
    logic [CAR_W-1:0]       waveVal;
    logic [CAR_W+AMP_W-1:0] prod;
    logic [CAR_W-1:0]       modVal;

    spwm_wave #(.POS_W(POS_W), .CAR_W(CAR_W)) uWave (
      .idx  (phaseIdx[ph]),
      .wave (waveVal)
    );

    assign prod   = {{AMP_W{1'b0}}, waveVal} * {{CAR_W{1'b0}}, ampQ};
    assign modVal = CAR_W'(prod >> AMP_W);
    assign demandNext[ph] = !refreshActive && (modVal > carrier);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ampQ       <= '0;
      leadQ      <= '0;
      leadOffQ   <= '0;
      pwmHigh    <= '0;
      lowRefresh <= 1'b0;
    end else begin
      if (strb.peak) begin
        ampQ     <= ampCmd;
        leadQ    <= clippedLead;
        leadOffQ <= leadOffNext;
      end
      pwmHigh    <= demandNext;
      lowRefresh <= refreshActive && strb.refreshWin;
    end
  end

  a_r8_amp_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.peak |=> $stable(ampQ));

  a_r8_lead_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.peak |=> $stable(leadQ));

  a_r6_clip_range: assert property (@(posedge clk) disable iff (rst)
    (strb.peak && leadLo <= leadHi) |=> (leadQ >= $past(leadLo) && leadQ <= $past(leadHi)));

  a_r7_clip_cross: assert property (@(posedge clk) disable iff (rst)
    (strb.peak && leadLo > leadHi) |=> (leadQ == $past(leadLo)));

  a_r9_refresh_off: assert property (@(posedge clk) disable iff (rst)
    refreshActive |=> (pwmHigh == '0));

  a_r9_no_low_pulse: assert property (@(posedge clk) disable iff (rst)
    !refreshActive |=> !lowRefresh);

  a_r3_peak_low: assert property (@(posedge clk) disable iff (rst)
    strb.peak |=> (pwmHigh == '0));

endmodule

// File: rtl/spwm_modulator.sv
module spwm_modulator
  import spwm_pkg::*;
#(
  parameter int CAR_W       = 6,
  parameter int AMP_W       = 8,
  parameter int POS_W       = 8,
  parameter int LA_W        = 5,
  parameter int LEAD_DEG    = 58,
  parameter int REFRESH_AMP = 16,
  parameter int REF_PCT     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AMP_W-1:0] ampCmd,
  input  logic [POS_W-1:0] rotorPos,
  input  logic [LA_W-1:0]  leadReq,
  input  logic [LA_W-1:0]  leadLo,
  input  logic [LA_W-1:0]  leadHi,
  output logic [2:0]       pwmHigh,
  output logic             lowRefresh,
  output logic             carrierPeak
);

  logic [CAR_W-1:0] carrier;
  spwmStrb_t        strb;

  spwm_ctrl #(.CAR_W(CAR_W), .REF_PCT(REF_PCT)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .carrier (carrier),
    .strb    (strb)
  );

  spwm_datapath #(
    .CAR_W(CAR_W), .AMP_W(AMP_W), .POS_W(POS_W), .LA_W(LA_W),
    .LEAD_DEG(LEAD_DEG), .REFRESH_AMP(REFRESH_AMP)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .carrier    (carrier),
    .strb       (strb),
    .ampCmd     (ampCmd),
    .rotorPos   (rotorPos),
    .leadReq    (leadReq),
    .leadLo     (leadLo),
    .leadHi     (leadHi),
    .pwmHigh    (pwmHigh),
    .lowRefresh (lowRefresh)
  );

  assign carrierPeak = strb.peak;

endmodule

// File: tb/tb_spwm_modulator.sv
module tb_spwm_modulator;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ampCmd = '0;
  logic [7:0] rotorPos = '0;
  logic [4:0] leadReq = '0;
  logic [4:0] leadLo = '0;
  logic [4:0] leadHi = 5'd31;
  logic [2:0] pwmHigh;
  logic       lowRefresh;
  logic       carrierPeak;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spwm_modulator dut (
    .clk(clk), .rst(rst), .ampCmd(ampCmd), .rotorPos(rotorPos),
    .leadReq(leadReq), .leadLo(leadLo), .leadHi(leadHi),
    .pwmHigh(pwmHigh), .lowRefresh(lowRefresh), .carrierPeak(carrierPeak)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected-value helpers taken from the requirement formulas.
  function automatic int waveRef(int p);
    int x = p % 128;
    int d = (x * (128 - x)) / 128;
    if (d > 31) d = 31;
    return (p >= 128) ? 32 - d : 32 + d;
  endfunction

  function automatic int dutyRef(int m);
    return (m == 0) ? 0 : 4 * m - 2;
  endfunction

  function automatic int clipRef(int req, int lo, int hi);
    if (lo > hi) return lo;
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  task automatic setIn(int amp, int pos, int req, int lo, int hi);
    @(negedge clk);
    ampCmd   = 8'(amp);
    rotorPos = 8'(pos);
    leadReq  = 5'(req);
    leadLo   = 5'(lo);
    leadHi   = 5'(hi);
  endtask

  task automatic waitPeak();
    do @(negedge clk); while (!carrierPeak);
  endtask

  task automatic countWindow(output int dU, output int dV, output int dW, output int dR);
    dU = 0; dV = 0; dW = 0; dR = 0;
    for (int i = 0; i < 252; i++) begin
      @(negedge clk);
      dU += int'(pwmHigh[0]);
      dV += int'(pwmHigh[1]);
      dW += int'(pwmHigh[2]);
      dR += int'(lowRefresh);
    end
  endtask

  task automatic runDuty(string req, int amp, int pos, int lreq, int lo, int hi);
    int dU, dV, dW, dR, off, base;
    int iU, iV, iW;
    setIn(amp, pos, lreq, lo, hi);
    waitPeak();
    countWindow(dU, dV, dW, dR);
    off  = clipRef(lreq, lo, hi) * 14848 / 11160;
    base = (pos + off) % 256;
    iU = base;
    iV = (base - 85 + 256) % 256;
    iW = (base - 171 + 256) % 256;
    if (amp < 16) begin
      check({req, " R9 U off"}, dU, 0);
      check({req, " R9 V off"}, dV, 0);
      check({req, " R9 W off"}, dW, 0);
      check({req, " R9 refresh"}, dR, 20);
    end else begin
      check({req, " R3 U"}, dU, dutyRef(waveRef(iU) * amp / 256));
      check({req, " R4 V"}, dV, dutyRef(waveRef(iV) * amp / 256));
      check({req, " R4 W"}, dW, dutyRef(waveRef(iW) * amp / 256));
      check({req, " R9 no refresh"}, dR, 0);
    end
  endtask

  task automatic testReset();
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 pwmHigh", int'(pwmHigh), 0);
    check("R10 lowRefresh", int'(lowRefresh), 0);
    check("R10 carrierPeak", int'(carrierPeak), 0);
    rst = 1'b0;
  endtask

  task automatic testPeakTiming();
    int early = 0;
    int later = 0;
    for (int i = 1; i <= 126; i++) begin
      @(negedge clk);
      if (i < 126) early += int'(carrierPeak);
      else check("R1 first peak", int'(carrierPeak), 1);
    end
    check("R1 no early peak", early, 0);
    for (int i = 1; i <= 252; i++) begin
      @(negedge clk);
      if (i < 252) later += int'(carrierPeak);
      else check("R1 second peak", int'(carrierPeak), 1);
    end
    check("R1 one peak per period", later, 0);
  endtask

  task automatic testSampleAtPeak();
    int dU, dV, dW, dR;
    int oldDuty = dutyRef(waveRef(0) * 255 / 256);
    runDuty("R8 base", 255, 0, 0, 0, 31);
    waitPeak();
    @(posedge clk);
    #1 ampCmd = 8'd64;
    countWindow(dU, dV, dW, dR);
    check("R8 old amplitude kept", dU, oldDuty);
    waitPeak();
    countWindow(dU, dV, dW, dR);
    check("R8 new amplitude applied", dU, dutyRef(waveRef(0) * 64 / 256));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testPeakTiming();
    runDuty("R2", 255, 0, 0, 0, 31);
    runDuty("R2", 128, 64, 0, 0, 31);
    runDuty("R4", 200, 200, 0, 0, 31);
    runDuty("R5", 255, 10, 31, 0, 31);
    runDuty("R5", 180, 30, 12, 0, 31);
    runDuty("R6 upper clip", 255, 0, 31, 0, 10);
    runDuty("R6 lower clip", 255, 0, 2, 9, 20);
    runDuty("R7 crossed", 255, 0, 0, 20, 5);
    runDuty("R9 refresh", 10, 0, 0, 0, 31);
    runDuty("R9 zero amp", 0, 100, 0, 0, 31);
    runDuty("R9 edge", 16, 0, 0, 0, 31);
    testSampleAtPeak();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule